// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Interface

This block is the host-facing register side of a two-channel serial controller. Each channel appears to the host as a pair of byte ports: a command port and a data port. Registers other than register 0 are reached indirectly. The host first writes a register number to the command port. The next command-port access then reads or writes that register, and the pointer falls back to 0. The data port passes bytes straight between the host and the character path.

The block keeps the write-side configuration: per-channel interrupt enables, a shared vector byte and a shared interrupt control byte. It assembles status bytes from latched line events. Six interrupt sources are ranked in a fixed order. Each is either a receive, transmit or external cause, on channel A or channel B. The block drives one interrupt request and a vector whose middle bits can name the winning cause. Serial shifting, baud generation and framing lie outside the block. They arrive as one-cycle event pulses per channel: character received, transmit buffer empty, external/status change, framing error and parity error.

Reading the vector register acknowledges the interrupt and puts the winning source under service. A command then retires the highest source under service, so interrupts nest by priority.

Top module: `sio_regfile`

## Requirements
- R1: After reset, register 0 of a channel reads 0x04 (bit 2 transmit buffer empty, bit 0 character available), register 1 reads 0x01 (bit 0 all sent), register 3 reads 0x00 and irq is low.
- R2: A command-port write with the pointer at 0 loads the pointer with bits 2:0, plus 8 when bits 5:3 hold 001. The next command-port access (read or write) reaches the selected register, and any such access returns the pointer to 0. Two reads in a row therefore always end on register 0.
- R3: host_addr 0 and 1 are channel B command and data, 2 and 3 are channel A command and data. A data write pulses tx_load for that channel (bit 1 = A, bit 0 = B) with tx_byte equal to the written byte, and clears transmit-empty. A data read returns that channel's receive byte and clears character-available.
- R4: Register 3 read through channel A gives {00, A receive, A transmit, A external, B receive, B transmit, B external} from bit 7 down to bit 0. Read through channel B it gives 0.
- R5: Register 1 bit 0 enables the external interrupt and bit 1 the transmit interrupt. An event becomes pending only while its enable is set. Command-port code 010 in bits 5:3 (0x10) clears the external pending bit. Code 101 (0x28) or a data write clears the transmit pending bit.
- R6: Register 1 bits 4:3 set the receive interrupt mode. 00 is none. 01 is first character only, re-armed by a write of register 1 or by error reset. 10 is every character, pending while a character is available. 11 is special condition only. A special condition is a latched framing error, or a latched parity error when register 1 bit 2 is set. It makes receive pending in every mode except 00. Register 1 (read) shows framing at bit 6 and parity at bit 4. Code 110 (0x30) clears both.
- R7: Register 2 read through channel A returns the stored vector unchanged. Through channel B with control bit 0 set, bits 3:1 are replaced by the winning cause. The resulting low nibble, with vector bit 0 = 0, is: B transmit 0x0, B external 0x2, B receive 0x4, B special 0x6, A transmit 0x8, A external 0xA, A receive 0xC, A special 0xE. With nothing pending it is 0x6.
- R8: Priority from highest to lowest is A receive, A transmit, A external, B receive, B transmit, B external. irq is high only when control bit 3 (master enable) is set, a source is pending, and no source at or above the highest pending one is under service.
- R9: A read of register 2 through either channel while irq is high and control bit 1 (no-vector) is clear puts the winning source under service. With no-vector set the read acknowledges nothing.
- R10: Command code 111 (0x38) on channel A releases the highest source under service. The same code on channel B has no effect.
- R11: Control register (register 9) writes store bits 3:0. A value with bits 7:6 = 11 resets both channels and clears the vector and control bytes. 10 resets channel A only and 01 channel B only, including their enables, latches, pending bits and under-service bits.
- R12: A higher-priority source raises irq while a lower one is under service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Port select: bit 1 channel (1 = A), bit 0 data port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of the read |
| rx_byte_a | input | 8 | Channel A received character |
| rx_byte_b | input | 8 | Channel B received character |
| tx_byte | output | 8 | Character handed to the transmit path |
| tx_load | output | 2 | Transmit load strobe per channel (1 = A, 0 = B) |
| ev_rx | input | 2 | Character received pulse per channel |
| ev_tx_empty | input | 2 | Transmit buffer became empty pulse per channel |
| ev_ext | input | 2 | External/status change pulse per channel |
| ev_frame_err | input | 2 | Framing error pulse per channel |
| ev_parity_err | input | 2 | Parity error pulse per channel |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take for granted that the host never raises the read and write strobes in the same cycle. The access decode gives each cycle a single meaning, and the under-service checks depend on that. Event pulses may arrive on any cycle and together with host accesses. The bench drives every host access as a single-cycle strobe and never overlaps a read with a write. It pulses events only between accesses, so the state it predicts for each check is reached through one known edge.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int DW    = 8;
  localparam int PW    = 4;
  localparam int NSRC  = 6;
  localparam int NCH   = 2;

  localparam logic [2:0] CMD_PT_HI  = 3'b001;
  localparam logic [2:0] CMD_RS_EXT = 3'b010;
  localparam logic [2:0] CMD_RS_TX  = 3'b101;
  localparam logic [2:0] CMD_RS_ERR = 3'b110;
  localparam logic [2:0] CMD_RS_IUS = 3'b111;

  localparam logic [PW-1:0] REG_STAT = 4'd0;
  localparam logic [PW-1:0] REG_ERRS = 4'd1;
  localparam logic [PW-1:0] REG_VEC  = 4'd2;
  localparam logic [PW-1:0] REG_PEND = 4'd3;
  localparam logic [PW-1:0] REG_CTRL = 4'd9;

  typedef enum logic [1:0] {RXI_OFF, RXI_FIRST, RXI_ALL, RXI_SPECIAL} rxi_mode_t;

  typedef struct packed {
    logic [PW-1:0] ptr;
    logic [DW-1:0] ien;
    logic          rx_avail;
    logic          tx_empty;
    logic          frame_err;
    logic          par_err;
    logic          first_armed;
    logic          first_ip;
    logic          tx_ip;
    logic          ext_ip;
  } chan_state_t;

  localparam chan_state_t CH_RESET = '{ptr: '0, ien: '0, rx_avail: 1'b0,
    tx_empty: 1'b1, frame_err: 1'b0, par_err: 1'b0, first_armed: 1'b1,
    first_ip: 1'b0, tx_ip: 1'b0, ext_ip: 1'b0};

  // Highest set bit as a one-hot vector; bit NSRC-1 ranks first.
  function automatic logic [NSRC-1:0] top_of(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (v[i]) r = NSRC'(1) << i;
    end
    return r;
  endfunction

  // Mask of all bits at or above a one-hot position.
  function automatic logic [NSRC-1:0] at_or_above(input logic [NSRC-1:0] onehot);
    return ~(onehot - NSRC'(1));
  endfunction

  // Cause nibble for the winning source (bit 0 always 0).
  function automatic logic [3:0] cause_code(input logic [NSRC-1:0] top,
                                            input logic sp_a, input logic sp_b);
    logic [3:0] c;
    unique case (top)
      6'b100000: c = sp_a ? 4'hE : 4'hC;
      6'b010000: c = 4'h8;
      6'b001000: c = 4'hA;
      6'b000100: c = sp_b ? 4'h6 : 4'h4;
      6'b000010: c = 4'h0;
      6'b000001: c = 4'h2;
      default:   c = 4'h6;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sio_chan.sv
module sio_chan
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_rst,
  input  logic          cmd_wr,
  input  logic          cmd_rd,
  input  logic          data_wr,
  input  logic          data_rd,
  input  logic [DW-1:0] wdata,
  input  logic          ev_rx,
  input  logic          ev_tx,
  input  logic          ev_ext,
  input  logic          ev_frame,
  input  logic          ev_par,
  output logic [PW-1:0] ptr,
  output logic [DW-1:0] stat0,
  output logic [DW-1:0] stat1,
  output logic          ip_rx,
  output logic          ip_sp,
  output logic          ip_tx,
  output logic          ip_ext
);
  chan_state_t st, nxt;
  rxi_mode_t   mode;
  logic [2:0]  code;

  assign mode = rxi_mode_t'(st.ien[4:3]);
  assign code = wdata[5:3];

  always_comb begin
    nxt = st;
    if (chan_rst) begin
      nxt = CH_RESET;
    end else begin
      if (cmd_wr) begin
        if (st.ptr == REG_STAT) begin
          nxt.ptr = {code == CMD_PT_HI, wdata[2:0]};
          if (code == CMD_RS_EXT) nxt.ext_ip = 1'b0;
          if (code == CMD_RS_TX)  nxt.tx_ip  = 1'b0;
          if (code == CMD_RS_ERR) begin
            nxt.frame_err   = 1'b0;
            nxt.par_err     = 1'b0;
            nxt.first_armed = 1'b1;
          end
        end else begin
          if (st.ptr == REG_ERRS) begin
            nxt.ien         = wdata;
            nxt.first_armed = 1'b1;
          end
          nxt.ptr = REG_STAT;
        end
      end
      if (cmd_rd) nxt.ptr = REG_STAT;
      if (data_wr) begin
        nxt.tx_empty = 1'b0;
        nxt.tx_ip    = 1'b0;
      end
      if (data_rd) begin
        nxt.rx_avail = 1'b0;
        nxt.first_ip = 1'b0;
      end
      if (ev_rx) begin
        nxt.rx_avail = 1'b1;
        if (st.first_armed && mode == RXI_FIRST) begin
          nxt.first_ip    = 1'b1;
          nxt.first_armed = 1'b0;
        end
      end
      if (ev_tx) begin
        nxt.tx_empty = 1'b1;
        if (st.ien[1]) nxt.tx_ip = 1'b1;
      end
      if (ev_ext && st.ien[0]) nxt.ext_ip = 1'b1;
      if (ev_frame) nxt.frame_err = 1'b1;
      if (ev_par)   nxt.par_err   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= CH_RESET;
    else        st <= nxt;
  end

  assign ptr    = st.ptr;
  assign stat0  = {5'b0, st.tx_empty, 1'b0, st.rx_avail};
  assign stat1  = {1'b0, st.frame_err, 1'b0, st.par_err, 3'b0, st.tx_empty};
  assign ip_sp  = (mode != RXI_OFF) && (st.frame_err || (st.ien[2] && st.par_err));
  assign ip_rx  = ((mode == RXI_ALL) && st.rx_avail) || st.first_ip;
  assign ip_tx  = st.tx_ip;
  assign ip_ext = st.ext_ip;
endmodule

// File: rtl/sio_irq_rank.sv
module sio_irq_rank
  import sio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic            sp_a,
  input  logic            sp_b,
  input  logic            mie,
  input  logic            ack,
  input  logic            ius_pop,
  input  logic            clr_a,
  input  logic            clr_b,
  output logic            irq,
  output logic [NSRC-1:0] top_src,
  output logic [NSRC-1:0] ius,
  output logic [3:0]      code
);
  localparam int HALF = NSRC / 2;
  logic [NSRC-1:0] ius_nxt, blocked;

  assign top_src = top_of(pend);
  assign blocked = ius & at_or_above(top_src);
  assign irq     = mie && (|pend) && !(|blocked);
  assign code    = cause_code(top_src, sp_a, sp_b);

  always_comb begin
    ius_nxt = ius;
    if (ack && irq) ius_nxt = ius_nxt | top_src;
    if (ius_pop)    ius_nxt = ius_nxt & ~top_of(ius);
    if (clr_a)      ius_nxt[NSRC-1:HALF] = '0;
    if (clr_b)      ius_nxt[HALF-1:0]    = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ius <= '0;
    else        ius <= ius_nxt;
  end
endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
  import sio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic [7:0]    rx_byte_a,
  input  logic [7:0]    rx_byte_b,
  output logic [7:0]    tx_byte,
  output logic [1:0]    tx_load,
  input  logic [1:0]    ev_rx,
  input  logic [1:0]    ev_tx_empty,
  input  logic [1:0]    ev_ext,
  input  logic [1:0]    ev_frame_err,
  input  logic [1:0]    ev_parity_err,
  output logic          irq
);
  localparam int CH_A = 1;
  localparam int CH_B = 0;

  logic [NCH-1:0][PW-1:0] ptr;
  logic [NCH-1:0][DW-1:0] stat0, stat1;
  logic [NCH-1:0]         ip_rx, ip_sp, ip_tx, ip_ext, chan_rst;
  logic [DW-1:0]          vec_q;
  logic [3:0]             ctrl_q;
  logic                   acc_ch, is_data;
  logic [PW-1:0]          cur_ptr;
  logic                   reg_wr, cmd0_wr, vec_wr, ctrl_wr, full_rst, ius_pop, ack;
  logic                   mie, no_vec, vis;
  logic [NSRC-1:0]        pend, top_src, ius;
  logic [3:0]             code;
  logic [DW-1:0]          vec_rd, pend_rd;

  assign acc_ch   = host_addr[1];
  assign is_data  = host_addr[0];
  assign cur_ptr  = ptr[acc_ch];
  assign reg_wr   = host_wr && !is_data && (cur_ptr != REG_STAT);
  assign cmd0_wr  = host_wr && !is_data && (cur_ptr == REG_STAT);
  assign vec_wr   = reg_wr && (cur_ptr == REG_VEC);
  assign ctrl_wr  = reg_wr && (cur_ptr == REG_CTRL);
  assign full_rst = ctrl_wr && (host_wdata[7:6] == 2'b11);
  assign ius_pop  = cmd0_wr && (acc_ch == 1'(CH_A)) && (host_wdata[5:3] == CMD_RS_IUS);
  assign ack      = host_rd && !is_data && (cur_ptr == REG_VEC) && !no_vec;
  assign mie      = ctrl_q[3];
  assign no_vec   = ctrl_q[1];
  assign vis      = ctrl_q[0];

  assign chan_rst[CH_A] = ctrl_wr && host_wdata[7];
  assign chan_rst[CH_B] = ctrl_wr && host_wdata[6];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic sel;
    assign sel = (acc_ch == 1'(i));
    sio_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_rst (chan_rst[i]),
      .cmd_wr   (host_wr && !is_data && sel),
      .cmd_rd   (host_rd && !is_data && sel),
      .data_wr  (host_wr && is_data && sel),
      .data_rd  (host_rd && is_data && sel),
      .wdata    (host_wdata),
      .ev_rx    (ev_rx[i]),
      .ev_tx    (ev_tx_empty[i]),
      .ev_ext   (ev_ext[i]),
      .ev_frame (ev_frame_err[i]),
      .ev_par   (ev_parity_err[i]),
      .ptr      (ptr[i]),
      .stat0    (stat0[i]),
      .stat1    (stat1[i]),
      .ip_rx    (ip_rx[i]),
      .ip_sp    (ip_sp[i]),
      .ip_tx    (ip_tx[i]),
      .ip_ext   (ip_ext[i])
    );
    assign tx_load[i] = host_wr && is_data && sel;
  end

  assign tx_byte = host_wdata;

  assign pend = {ip_rx[CH_A] | ip_sp[CH_A], ip_tx[CH_A], ip_ext[CH_A],
                 ip_rx[CH_B] | ip_sp[CH_B], ip_tx[CH_B], ip_ext[CH_B]};

  sio_irq_rank u_rank (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .sp_a    (ip_sp[CH_A]),
    .sp_b    (ip_sp[CH_B]),
    .mie     (mie),
    .ack     (ack),
    .ius_pop (ius_pop),
    .clr_a   (chan_rst[CH_A]),
    .clr_b   (chan_rst[CH_B]),
    .irq     (irq),
    .top_src (top_src),
    .ius     (ius),
    .code    (code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      ctrl_q <= '0;
    end else if (full_rst) begin
      vec_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (vec_wr)  vec_q  <= host_wdata;
      if (ctrl_wr) ctrl_q <= host_wdata[3:0];
    end
  end

  assign vec_rd  = (acc_ch == 1'(CH_B) && vis) ? {vec_q[7:4], code[3:1], vec_q[0]} : vec_q;
  assign pend_rd = (acc_ch == 1'(CH_A)) ? {2'b00, pend} : '0;

  always_comb begin
    host_rdata = '0;
    if (is_data) begin
      host_rdata = acc_ch ? rx_byte_a : rx_byte_b;
    end else begin
      unique case (cur_ptr)
        REG_STAT: host_rdata = stat0[acc_ch];
        REG_ERRS: host_rdata = stat1[acc_ch];
        REG_VEC:  host_rdata = vec_rd;
        REG_PEND: host_rdata = pend_rd;
        default:  host_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sio_regfile_chk.sv
module sio_regfile_chk
  import sio_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_wr,
  input logic                   host_rd,
  input logic [1:0]             host_addr,
  input logic [7:0]             host_rdata,
  input logic                   irq,
  input logic                   mie,
  input logic [NSRC-1:0]        top_src,
  input logic [NSRC-1:0]        ius,
  input logic [NCH-1:0][PW-1:0] ptr
);
  // Input rule: one host access kind per cycle
  exclusive_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_rd));

  // R2
  ptr_a_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && host_addr == 2'd2 && ptr[1] != '0) |=> (ptr[1] == '0));

  // R2
  ptr_b_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((host_wr || host_rd) && host_addr == 2'd0 && ptr[0] != '0) |=> (ptr[0] == '0));

  // R4
  pend_b_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd0 && ptr[0] == 4'd3) |-> (host_rdata == 8'h00));

  // R8
  irq_needs_mie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mie);

  // R8
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(top_src));

  // R9
  ius_grow_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd || !irq) |=> ($countones(ius) <= $countones($past(ius))));
endmodule

bind sio_regfile sio_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_rdata (host_rdata),
  .irq        (irq),
  .mie        (mie),
  .top_src    (top_src),
  .ius        (ius),
  .ptr        (ptr)
);

// File: tb/tb_sio_regfile.sv
module tb_sio_regfile;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] rx_byte_a = '0, rx_byte_b = '0;
  logic [7:0] tx_byte;
  logic [1:0] tx_load;
  logic [1:0] ev_rx = '0, ev_tx_empty = '0, ev_ext = '0, ev_frame_err = '0, ev_parity_err = '0;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  localparam logic [1:0] B_CMD = 2'd0, B_DAT = 2'd1, A_CMD = 2'd2, A_DAT = 2'd3;

  sio_regfile dut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic sel(input logic [1:0] a, input int r);
    if (r >= 8) wr(a, 8'h08 | 8'(r - 8));
    else        wr(a, 8'(r));
  endtask

  task automatic wreg(input logic [1:0] a, input int r, input logic [7:0] v);
    sel(a, r);
    wr(a, v);
  endtask

  task automatic rreg(input logic [1:0] a, input int r, output logic [7:0] v);
    if (r != 0) sel(a, r);
    rd(a, v);
  endtask

  task automatic pulse(input logic [1:0] rx, input logic [1:0] tx, input logic [1:0] ex,
                       input logic [1:0] fr, input logic [1:0] pa);
    @(negedge clk);
    ev_rx = rx; ev_tx_empty = tx; ev_ext = ex; ev_frame_err = fr; ev_parity_err = pa;
    @(negedge clk);
    ev_rx = '0; ev_tx_empty = '0; ev_ext = '0; ev_frame_err = '0; ev_parity_err = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(A_CMD, 0, v); chk("R1 stat0 A", v, 8'h04);
    rreg(B_CMD, 1, v); chk("R1 stat1 B", v, 8'h01);
    rreg(A_CMD, 3, v); chk("R1 pending", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_pointer();
    logic [7:0] v;
    wr(A_CMD, 8'h03);
    rd(A_CMD, v); chk("R2 selected reg 3", v, 8'h00);
    rd(A_CMD, v); chk("R2 back to reg 0", v, 8'h04);
    wr(B_CMD, 8'h0A);
    rd(B_CMD, v); chk("R2 point-high reg 10", v, 8'h00);
    rd(B_CMD, v); chk("R2 two reads end on reg 0", v, 8'h04);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wreg(A_CMD, 2, 8'h50);
    wreg(A_CMD, 9, 8'h09);
    wreg(A_CMD, 1, 8'h01);
    pulse(2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
    chk("R8 irq on A ext", {7'b0, irq}, 8'h01);
    rreg(A_CMD, 3, v); chk("R4 pending via A", v, 8'h08);
    rreg(B_CMD, 3, v); chk("R4 pending via B zero", v, 8'h00);
    rreg(B_CMD, 2, v); chk("R7 vector A ext", v, 8'h5A);
    chk("R9 ack drops irq", {7'b0, irq}, 8'h00);
    wr(A_CMD, 8'h10);
    rreg(A_CMD, 3, v); chk("R5 reset ext pending", v, 8'h00);
    wr(B_CMD, 8'h38);
    pulse(2'b00, 2'b00, 2'b10, 2'b00, 2'b00);
    chk("R10 release via B ignored", {7'b0, irq}, 8'h00);
    wr(A_CMD, 8'h38);
    chk("R10 release via A", {7'b0, irq}, 8'h01);
    wr(A_CMD, 8'h10);
    chk("R5 cleared ext", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] v;
    wreg(B_CMD, 1, 8'h02);
    wreg(A_CMD, 9, 8'h0B);
    pulse(2'b00, 2'b01, 2'b10, 2'b00, 2'b00);
    chk("R8 irq two sources", {7'b0, irq}, 8'h01);
    rreg(A_CMD, 2, v); chk("R7 raw vector via A", v, 8'h50);
    rreg(B_CMD, 2, v); chk("R8 A ext outranks B tx", v, 8'h5A);
    chk("R9 no-vector keeps irq", {7'b0, irq}, 8'h01);
    wreg(A_CMD, 9, 8'h09);
    rreg(B_CMD, 2, v); chk("R7 vector before ack", v, 8'h5A);
    chk("R8 B tx blocked by service", {7'b0, irq}, 8'h00);
    rreg(A_CMD, 3, v); chk("R4 two pending", v, 8'h0A);
    wr(A_CMD, 8'h10);
    chk("R8 still blocked", {7'b0, irq}, 8'h00);
    wr(A_CMD, 8'h38);
    chk("R8 B tx after release", {7'b0, irq}, 8'h01);
    rreg(B_CMD, 2, v); chk("R7 vector B tx", v, 8'h50);
    chk("R9 ack B tx", {7'b0, irq}, 8'h00);
    rx_byte_a = 8'hA5;
    wreg(A_CMD, 1, 8'h11);
    pulse(2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
    chk("R12 nested A rx", {7'b0, irq}, 8'h01);
    rreg(B_CMD, 2, v); chk("R7 vector A rx", v, 8'h5C);
    rd(A_DAT, v); chk("R3 data read A", v, 8'hA5);
    wr(A_CMD, 8'h38);
    chk("R10 one release leaves B tx", {7'b0, irq}, 8'h00);
    wr(A_CMD, 8'h38);
    chk("R10 second release", {7'b0, irq}, 8'h01);
    wr(B_CMD, 8'h28);
    chk("R5 reset tx pending", {7'b0, irq}, 8'h00);
    rreg(A_CMD, 3, v); chk("R5 nothing pending", v, 8'h00);
  endtask

  task automatic t_rx_modes();
    logic [7:0] v;
    wreg(A_CMD, 9, 8'h0B);
    rx_byte_b = 8'h11;
    wreg(B_CMD, 1, 8'h08);
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R6 first char", v, 8'h04);
    rreg(B_CMD, 0, v); chk("R6 char available", v, 8'h05);
    rd(B_DAT, v); chk("R3 data read B", v, 8'h11);
    rreg(A_CMD, 3, v); chk("R6 first cleared by read", v, 8'h00);
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R6 second char silent", v, 8'h00);
    rd(B_DAT, v);
    wreg(B_CMD, 1, 8'h10);
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R6 every char", v, 8'h04);
    rd(B_DAT, v);
    wreg(B_CMD, 1, 8'h18);
    pulse(2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R6 special-only ignores char", v, 8'h00);
    rd(B_DAT, v);
    pulse(2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
    rreg(A_CMD, 3, v); chk("R6 parity not special", v, 8'h00);
    rreg(B_CMD, 1, v); chk("R6 parity latched", v, 8'h11);
    wreg(B_CMD, 1, 8'h1C);
    rreg(A_CMD, 3, v); chk("R6 parity as special", v, 8'h04);
    rreg(B_CMD, 2, v); chk("R7 vector B special", v, 8'h56);
    wreg(A_CMD, 1, 8'h18);
    pulse(2'b00, 2'b00, 2'b00, 2'b10, 2'b00);
    rreg(B_CMD, 2, v); chk("R7 vector A special", v, 8'h5E);
    rreg(A_CMD, 1, v); chk("R6 framing latched", v, 8'h41);
    wr(A_CMD, 8'h30);
    wr(B_CMD, 8'h30);
    rreg(B_CMD, 1, v); chk("R6 error reset", v, 8'h01);
    rreg(B_CMD, 2, v); chk("R7 vector none pending", v, 8'h56);
  endtask

  task automatic t_data();
    logic [7:0] v;
    @(negedge clk);
    host_addr = A_DAT; host_wdata = 8'h3C; host_wr = 1'b1;
    #1 chk("R3 tx_load A", {6'b0, tx_load}, 8'h02);
    chk("R3 tx_byte", tx_byte, 8'h3C);
    @(negedge clk);
    host_wr = 1'b0;
    rreg(A_CMD, 0, v); chk("R3 tx empty cleared", v, 8'h00);
    pulse(2'b00, 2'b10, 2'b00, 2'b00, 2'b00);
    rreg(A_CMD, 0, v); chk("R3 tx empty again", v, 8'h04);
  endtask

  task automatic t_resets();
    logic [7:0] v;
    wreg(B_CMD, 1, 8'h01);
    wreg(A_CMD, 1, 8'h01);
    pulse(2'b00, 2'b00, 2'b11, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R11 both ext pending", v, 8'h09);
    wreg(A_CMD, 9, 8'h4B);
    rreg(A_CMD, 3, v); chk("R11 B reset", v, 8'h08);
    chk("R11 control kept", {7'b0, irq}, 8'h01);
    pulse(2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
    rreg(A_CMD, 3, v); chk("R11 B enables cleared", v, 8'h08);
    wreg(B_CMD, 9, 8'h8B);
    rreg(A_CMD, 3, v); chk("R11 A reset", v, 8'h00);
    wr(A_DAT, 8'h77);
    wreg(A_CMD, 9, 8'hC0);
    rreg(A_CMD, 2, v); chk("R11 full reset vector", v, 8'h00);
    rreg(A_CMD, 0, v); chk("R11 full reset status", v, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pointer();
    t_ext();
    t_prio();
    t_rx_modes();
    t_data();
    t_resets();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule